// File: doc/BRIEF.md
# Split Counter Update Unit

This unit advances the per-page encryption counter line each time one data line of that page is written back to persistent memory. A counter line packs a single wide page counter (the major part) together with one small per-line counter (minor) for every data line of the page. Given the current counter line, the index of the written data line and the bank the data write targets, the unit bumps that line's minor, builds the encryption seed from the page counter and the new minor, and returns the updated counter line together with the bank the counter write must use.

When the selected minor is already at its largest value, the step rolls the page over: every minor returns to zero, the page counter advances by one, and the result beat carries a page re-encryption flag together with the page counter as it was before the step. Every updated counter line leaves the unit for persistence, so a counter cache in front of it never holds dirty lines; dropping one of its entries is a plain invalidate. Pad generation and the memory access are outside this unit.

Requests enter through a valid/ready stream and results leave through another, with one register stage between them. A request is taken in a cycle where `in_valid` and `in_ready` are both high. The result stays on the output, unchanged, until `out_ready` is seen high with `out_valid`; while it waits, `in_ready` is low. A new request may be taken in the same cycle a held result is consumed.

Top module: `split_ctr_update`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: The counter line keeps the page counter in bits [MAJ_W-1:0] and minor i in bits [MAJ_W+MIN_W*i +: MIN_W]; when the selected minor is below all-ones, the result line has that minor raised by one and every other minor and the page counter unchanged.
- R3: The seed is MAJ_W+MIN_W bits wide, with the result line's page counter in the upper MAJ_W bits and the selected line's result minor in the lower MIN_W bits.
- R4: When the selected minor is all-ones, every minor of the result line is zero, the page counter is one higher, and `out_reenc` is high.
- R5: `out_reenc` is low whenever the selected minor was below all-ones.
- R6: `out_old_major` equals the page counter of the accepted input line.
- R7: `out_bank` equals (`in_bank` + BANKS/2) mod BANKS, BANKS being a power of two.
- R8: A request accepted at one clock edge appears on the output with `out_valid` high right after that edge.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold their values.
- R10: A rollover with the page counter at all-ones wraps it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_line | input | LINE_W | Current counter line of the page |
| in_idx | input | IDX_W | Data line index within the page |
| in_bank | input | BANK_W | Bank of the data write |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_line | output | LINE_W | Updated counter line |
| out_seed | output | SEED_W | Page counter joined with the selected minor |
| out_old_major | output | MAJ_W | Page counter before the update |
| out_reenc | output | 1 | Page re-encryption request |
| out_bank | output | BANK_W | Bank for the counter write |

## Verification
The rarest situation is a rollover: with full-size 7-bit minors a given line needs 127 write-backs before its minor wraps, and the page counter wrap needs far more. The bench instead uses a narrow configuration (3-bit minors, 8-bit page counter, eight lines, four banks) and preloads the input line with chosen values, so every lane is visited at every minor value including all-ones, and one step starts with the page counter at all-ones. A stall with a second request waiting is driven directly by holding `out_ready` low.

// File: rtl/scu_pkg.sv
package scu_pkg;
  typedef enum logic [0:0] {
    STEP_MINOR = 1'b0,
    ROLL_PAGE  = 1'b1
  } upd_kind_e;
endpackage

// File: rtl/scu_line_next.sv
module scu_line_next
  import scu_pkg::*;
#(
  parameter int MAJ_W = 64,
  parameter int MIN_W = 7,
  parameter int LINES = 64,
  localparam int LINE_W = MAJ_W + LINES * MIN_W,
  localparam int IDX_W  = $clog2(LINES),
  localparam int SEED_W = MAJ_W + MIN_W
) (
  input  logic [LINE_W-1:0] cur_line,
  input  logic [IDX_W-1:0]  idx,
  output logic [LINE_W-1:0] nxt_line,
  output logic [SEED_W-1:0] seed,
  output upd_kind_e         kind
);
  logic [MIN_W-1:0] cur_min [LINES];
  logic [MIN_W-1:0] nxt_min [LINES];
  logic [MAJ_W-1:0] cur_maj;
  logic [MAJ_W-1:0] nxt_maj;
  logic [MIN_W-1:0] sel_min;
  logic             roll;

  assign cur_maj = cur_line[MAJ_W-1:0];

  // per-lane unpack, step and repack
  for (genvar g = 0; g < LINES; g++) begin : g_lane
    assign cur_min[g] = cur_line[MAJ_W + g*MIN_W +: MIN_W];
    assign nxt_min[g] = roll ? '0
                      : (idx == IDX_W'(g)) ? cur_min[g] + MIN_W'(1)
                      : cur_min[g];
    assign nxt_line[MAJ_W + g*MIN_W +: MIN_W] = nxt_min[g];
  end

  assign sel_min = cur_min[idx];
  assign roll    = &sel_min;
  assign nxt_maj = cur_maj + MAJ_W'(roll);
  assign nxt_line[MAJ_W-1:0] = nxt_maj;
  assign seed    = {nxt_maj, nxt_min[idx]};
  assign kind    = roll ? ROLL_PAGE : STEP_MINOR;
endmodule

// File: rtl/scu_bank_steer.sv
module scu_bank_steer #(
  parameter int BANKS = 8,
  localparam int BANK_W = $clog2(BANKS),
  localparam int HALF   = BANKS / 2
) (
  input  logic [BANK_W-1:0] data_bank,
  output logic [BANK_W-1:0] ctr_bank
);
  // power-of-two bank count: the add wraps modulo BANKS
  assign ctr_bank = data_bank + BANK_W'(HALF);
endmodule

// File: rtl/scu_out_reg.sv
module scu_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) dn_data <= up_data;
  end
endmodule

// File: rtl/split_ctr_update.sv
module split_ctr_update
  import scu_pkg::*;
#(
  parameter int MAJ_W = 64,
  parameter int MIN_W = 7,
  parameter int LINES = 64,
  parameter int BANKS = 8,
  localparam int LINE_W = MAJ_W + LINES * MIN_W,
  localparam int IDX_W  = $clog2(LINES),
  localparam int BANK_W = $clog2(BANKS),
  localparam int SEED_W = MAJ_W + MIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LINE_W-1:0] in_line,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [BANK_W-1:0] in_bank,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LINE_W-1:0] out_line,
  output logic [SEED_W-1:0] out_seed,
  output logic [MAJ_W-1:0]  out_old_major,
  output logic              out_reenc,
  output logic [BANK_W-1:0] out_bank
);
  localparam int PAY_W = LINE_W + SEED_W + MAJ_W + 1 + BANK_W;

  logic [LINE_W-1:0] nxt_line;
  logic [SEED_W-1:0] nxt_seed;
  upd_kind_e         kind;
  logic [BANK_W-1:0] ctr_bank;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  scu_line_next #(.MAJ_W(MAJ_W), .MIN_W(MIN_W), .LINES(LINES)) u_next (
    .cur_line (in_line),
    .idx      (in_idx),
    .nxt_line (nxt_line),
    .seed     (nxt_seed),
    .kind     (kind)
  );

  scu_bank_steer #(.BANKS(BANKS)) u_steer (
    .data_bank (in_bank),
    .ctr_bank  (ctr_bank)
  );

  assign pay_in = {nxt_line, nxt_seed, in_line[MAJ_W-1:0],
                   (kind == ROLL_PAGE), ctr_bank};

  scu_out_reg #(.W(PAY_W)) u_oreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign {out_line, out_seed, out_old_major, out_reenc, out_bank} = pay_out;
endmodule

// File: rtl/scu_checker.sv
module scu_checker #(
  parameter int MAJ_W = 64,
  parameter int MIN_W = 7,
  parameter int LINES = 64,
  parameter int BANKS = 8,
  localparam int LINE_W = MAJ_W + LINES * MIN_W,
  localparam int BANK_W = $clog2(BANKS),
  localparam int SEED_W = MAJ_W + MIN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LINE_W-1:0] in_line,
  input logic [BANK_W-1:0] in_bank,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LINE_W-1:0] out_line,
  input logic [SEED_W-1:0] out_seed,
  input logic [MAJ_W-1:0]  out_old_major,
  input logic              out_reenc,
  input logic [BANK_W-1:0] out_bank
);
  AST_SEED_MAJOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_seed[SEED_W-1:MIN_W] == out_line[MAJ_W-1:0]); // R3
  AST_ROLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_reenc) |-> (out_line[LINE_W-1:MAJ_W] == '0 && out_seed[MIN_W-1:0] == '0)); // R4
  AST_MAJOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_line[MAJ_W-1:0] == $past(in_line[MAJ_W-1:0]) + MAJ_W'(out_reenc)); // R4
  AST_OLD_MAJOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_old_major == $past(in_line[MAJ_W-1:0])); // R6
  AST_BANK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_bank == ($past(in_bank) + BANK_W'(BANKS/2))); // R7
  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_line) && $stable(out_seed)
      && $stable(out_bank) && $stable(out_reenc) && $stable(out_old_major))); // R9
endmodule

bind split_ctr_update scu_checker #(
  .MAJ_W(MAJ_W), .MIN_W(MIN_W), .LINES(LINES), .BANKS(BANKS)
) i_scu_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_line(in_line), .in_bank(in_bank), .out_valid(out_valid),
  .out_ready(out_ready), .out_line(out_line), .out_seed(out_seed),
  .out_old_major(out_old_major), .out_reenc(out_reenc), .out_bank(out_bank)
);

// File: tb/test_split_ctr_update.sv
`timescale 1ns/1ps
module test_split_ctr_update;
  localparam int MAJ_W  = 8;
  localparam int MIN_W  = 3;
  localparam int LINES  = 8;
  localparam int BANKS  = 4;
  localparam int LINE_W = MAJ_W + LINES * MIN_W;
  localparam int IDX_W  = 3;
  localparam int BANK_W = 2;
  localparam int SEED_W = MAJ_W + MIN_W;
  localparam int MINMAX = (1 << MIN_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [LINE_W-1:0] in_line = '0;
  logic [IDX_W-1:0]  in_idx = '0;
  logic [BANK_W-1:0] in_bank = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [LINE_W-1:0] out_line;
  logic [SEED_W-1:0] out_seed;
  logic [MAJ_W-1:0]  out_old_major;
  logic              out_reenc;
  logic [BANK_W-1:0] out_bank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  split_ctr_update #(.MAJ_W(MAJ_W), .MIN_W(MIN_W), .LINES(LINES), .BANKS(BANKS))
  i_split_ctr_update (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_line(in_line), .in_idx(in_idx), .in_bank(in_bank),
    .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line),
    .out_seed(out_seed), .out_old_major(out_old_major),
    .out_reenc(out_reenc), .out_bank(out_bank)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] mk_line(input int maj, input int idx,
                                               input int v);
    logic [LINE_W-1:0] l;
    l[MAJ_W-1:0] = MAJ_W'(maj);
    for (int j = 0; j < LINES; j++)
      l[MAJ_W + j*MIN_W +: MIN_W] = (j == idx) ? MIN_W'(v) : MIN_W'(j*5 + idx);
    return l;
  endfunction

  // expected results computed from the requirements
  task automatic check_result(input logic [LINE_W-1:0] l, input int idx,
                              input int bank, input string tag);
    logic [LINE_W-1:0] el;
    int maj, v, emaj, emin;
    maj = int'(l[MAJ_W-1:0]);
    v   = int'(l[MAJ_W + idx*MIN_W +: MIN_W]);
    if (v == MINMAX) begin
      emaj = (maj + 1) % (1 << MAJ_W);
      emin = 0;
      el = '0;
      el[MAJ_W-1:0] = MAJ_W'(emaj);
      chk("R4", {tag, " rolled line"}, 64'(out_line), 64'(el));
      chk("R4", {tag, " reenc"}, 64'(out_reenc), 64'd1);
    end else begin
      emaj = maj;
      emin = v + 1;
      el = l;
      el[MAJ_W + idx*MIN_W +: MIN_W] = MIN_W'(emin);
      chk("R2", {tag, " stepped line"}, 64'(out_line), 64'(el));
      chk("R5", {tag, " reenc"}, 64'(out_reenc), 64'd0);
    end
    chk("R3", {tag, " seed"}, 64'(out_seed), 64'((emaj << MIN_W) | emin));
    chk("R6", {tag, " old major"}, 64'(out_old_major), 64'(maj));
    chk("R7", {tag, " bank"}, 64'(out_bank), 64'((bank + BANKS/2) % BANKS));
  endtask

  task automatic xfer(input logic [LINE_W-1:0] l, input int idx, input int bank,
                      input string tag);
    @(negedge clk);
    in_line  = l;
    in_idx   = IDX_W'(idx);
    in_bank  = BANK_W'(bank);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", {tag, " out_valid"}, 64'(out_valid), 64'd1);
    check_result(l, idx, bank, tag);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [LINE_W-1:0] l1, l2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "out_valid", 64'(out_valid), 64'd0);
    chk("R1", "in_ready", 64'(in_ready), 64'd1);

    // sweep every lane, every minor value, banks rotating
    for (int idx = 0; idx < LINES; idx++)
      for (int v = 0; v <= MINMAX; v++)
        xfer(mk_line((idx*37 + v*11) % 255, idx, v), idx, (idx + v) % BANKS, "sweep");

    // R10 page counter wrap on rollover
    xfer(mk_line(255, 5, MINMAX), 5, 3, "R10 wrap");
    chk("R10", "wrapped major", 64'(out_line[MAJ_W-1:0]), 64'd0);

    // R9 stall with a second request waiting
    l1 = mk_line(17, 2, 3);
    l2 = mk_line(99, 6, MINMAX);
    @(negedge clk);
    out_ready = 1'b0;
    in_line = l1; in_idx = 3'd2; in_bank = 2'd1; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_line = l2; in_idx = 3'd6; in_bank = 2'd3;
    chk("R9", "in_ready while stalled", 64'(in_ready), 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "still valid", 64'(out_valid), 64'd1);
    check_result(l1, 2, 1, "R9 held");
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "second beat valid", 64'(out_valid), 64'd1);
    check_result(l2, 6, 3, "R9 after release");
    @(posedge clk);
    @(negedge clk);
    chk("R8", "drained", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule